// File: doc/BRIEF.md
# Upset-Tolerant Redundant-Stream Multiplier

This block multiplies two unsigned operands (8 bits each by default) and keeps the right product when several stored bits flip in the same cycle. Each partial-product bit `a[i] AND b[j]` is built by a small cell of parallel AND gates, so it exists as a group of identical replica bits. The block gathers the replicas of every partial product that shares a weight `2^c` into one column stream. It adds a few bias bits tied to one, counts the ones in each column and drops the low bits of that count. The result is the column's partial-product sum, which comes out exact as long as the net error in that column stays inside a fixed window.

The weighted column sums are added into a binary product, which is registered on the rising clock edge. A fault mask input has one bit per stream bit. Each mask bit is XORed into its stream bit before counting, so a bench can inject upsets at known positions. The counters and the final adder are not hardened.

Top module: `rsm_mult`

## Requirements
- R1: With an all-zero fault mask, `product` equals `op_a * op_b` one rising clock edge after the operands are applied.
- R2: A high `rst` at a rising edge clears `product` to 0, whatever the operands and mask.
- R3: Mask layout (W=8, REP=8, BIAS=4, 572 bits): the bit at index `(i*8+j)*8 + r` flips replica r of `a[i] AND b[j]`, which belongs to column `c = i+j`. The bit at index `512 + c*4 + k` flips bias bit k of column c. Bias bits are one when not flipped.
- R4: Up to 3 net 0-to-1 flips in any one column have no effect on `product`.
- R5: Up to 4 net 1-to-0 flips in any one column have no effect on `product`.
- R6: Flips of opposite direction in the same column cancel one for one. Only the net count is limited.
- R7: A flipped bias bit counts as a 1-to-0 flip of its column, the same as a flipped data replica.
- R8: Flips spread over all columns at once, each column within its limits, leave `product` equal to `op_a * op_b`.
- R9: Each column sum is `floor(ones/8)`. A net error of +4 to +11 in column c adds `2^c` to the product, and a net error of -5 to -12 subtracts `2^c`. The result wraps modulo 2^16.
- R10: While the operands and the mask stay unchanged, `product` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| flip_mask | input | 572 | Fault mask XORed into the stream bits (layout in R3) |
| product | output | 16 | Registered binary product |

## Verification
Every result passes through exactly one register, so `product` reflects the operands and mask that were present at the previous rising edge. The bench drives each new stimulus on a falling edge and reads `product` on the next falling edge, one edge after the register captured it. The reset checks read the output on the falling edge that follows the reset edge. The stability check reads the output on two consecutive falling edges with the inputs held.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    // number of partial products whose weight is 2^c for a w x w multiply
    function automatic int col_terms(input int c, input int w);
        int lo;
        int hi;
        lo = c + 1;
        hi = 2 * w - 1 - c;
        return (lo < hi) ? lo : hi;
    endfunction

    // index of the lowest a-operand bit that feeds column c
    function automatic int col_first(input int c, input int w);
        return (c > w - 1) ? (c - w + 1) : 0;
    endfunction
endpackage

// File: rtl/rsm_cell.sv
module rsm_cell #(
    parameter int REP = 8
) (
    input  logic           a_bit,
    input  logic           b_bit,
    input  logic [REP-1:0] flip,
    output logic [REP-1:0] rep
);
    // one independent AND gate per replica, then the injected upsets
    for (genvar r = 0; r < REP; r++) begin : g_rep
        assign rep[r] = (a_bit & b_bit) ^ flip[r];
    end
endmodule

// File: rtl/rsm_column.sv
module rsm_column #(
    parameter int NT   = 8,
    parameter int REP  = 8,
    parameter int BIAS = 4,
    parameter int SW   = 4
) (
    input  logic [REP*NT+BIAS-1:0] bits,
    output logic [SW-1:0]          sum
);
    localparam int NB = REP * NT + BIAS;
    localparam int CW = $clog2(NB + 1);
    localparam int LG = $clog2(REP);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int n = 0; n < NB; n++) begin
            ones = ones + CW'(bits[n]);
        end
    end

    // the low bits absorb the bounded error window around REP*sum+BIAS
    assign sum = SW'(ones >> LG);
endmodule

// File: rtl/rsm_mult.sv
module rsm_mult #(
    parameter int W    = 8,
    parameter int REP  = 8,
    parameter int BIAS = REP / 2,
    parameter int FW   = W * W * REP + (2 * W - 1) * BIAS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [FW-1:0]   flip_mask,
    output logic [2*W-1:0]  product
);
    localparam int NCOL  = 2 * W - 1;
    localparam int PW    = 2 * W;
    localparam int SW    = $clog2(W + 1);
    localparam int BBASE = W * W * REP;

    logic [REP-1:0] pp   [W][W];
    logic [SW-1:0]  csum [NCOL];
    logic [PW-1:0]  acc;

    // robust 1-bit multipliers, one per (i, j)
    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_cell
            rsm_cell #(.REP(REP)) u_cell (
                .a_bit (op_a[i]),
                .b_bit (op_b[j]),
                .flip  (flip_mask[((i * W) + j) * REP +: REP]),
                .rep   (pp[i][j])
            );
        end
    end

    // column streams: bias bits first, then replicas by ascending a index
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam int NT = rsm_pkg::col_terms(c, W);
        localparam int LO = rsm_pkg::col_first(c, W);
        logic [REP*NT+BIAS-1:0] cbits;

        assign cbits[BIAS-1:0] = {BIAS{1'b1}} ^ flip_mask[BBASE + c * BIAS +: BIAS];
        for (genvar k = 0; k < NT; k++) begin : g_term
            assign cbits[BIAS + k * REP +: REP] = pp[LO + k][c - LO - k];
        end

        rsm_column #(.NT(NT), .REP(REP), .BIAS(BIAS), .SW(SW)) u_col (
            .bits (cbits),
            .sum  (csum[c])
        );
    end

    // weighted recombination of the column sums
    always_comb begin
        acc = '0;
        for (int c = 0; c < NCOL; c++) begin
            acc = acc + (PW'(csum[c]) << c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
        end else begin
            product <= acc;
        end
    end

    // R1
    fault_free_chk: assert property (@(posedge clk) disable iff (rst)
        (flip_mask == '0) |=> (product == PW'($past(op_a)) * PW'($past(op_b))));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (product == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(op_a) && $stable(op_b) && $stable(flip_mask) && !$past(rst))
        |=> $stable(product));

    // R1
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_a == '0 || op_b == '0) && flip_mask == '0) |=> (product == '0));
endmodule

// File: tb/tb_rsm_mult.sv
module tb_rsm_mult;
    localparam int W    = 8;
    localparam int REP  = 8;
    localparam int BIAS = 4;
    localparam int FW   = W * W * REP + (2 * W - 1) * BIAS;
    localparam int NCOL = 2 * W - 1;
    localparam int NROW = 13;

    // a, b, column, wanted 0->1 flips, wanted 1->0 flips
    localparam logic [7:0] T_A  [NROW] = '{8'd0, 8'd255, 8'd13, 8'd200, 8'd255, 8'd0, 8'd170,
                                          8'd255, 8'd0, 8'd0, 8'd255, 8'd77, 8'd255};
    localparam logic [7:0] T_B  [NROW] = '{8'd0, 8'd255, 8'd11, 8'd3, 8'd255, 8'd0, 8'd85,
                                          8'd255, 8'd0, 8'd0, 8'd255, 8'd201, 8'd255};
    localparam int         T_C  [NROW] = '{0, 7, 0, 5, 7, 3, 8, 14, 0, 2, 0, 6, 14};
    localparam int         T_UP [NROW] = '{0, 0, 0, 3, 0, 3, 5, 0, 0, 4, 0, 7, 0};
    localparam int         T_DN [NROW] = '{0, 0, 0, 0, 4, 0, 5, 4, 4, 0, 5, 3, 12};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic [FW-1:0]  flip_mask = '0;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsm_mult dut (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .flip_mask (flip_mask),
        .product   (product)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: product=%0d expected=%0d", req, act, exp);
        end
    endtask

    // flips up to 'up' zero bits and 'dn' one bits of column c (bias bits scanned first), R3 layout
    task automatic add_flips(input logic [7:0] a, input logic [7:0] b, input int c,
                             input int up, input int dn, inout logic [FW-1:0] m,
                             output int got_up, output int got_dn);
        got_up = 0;
        got_dn = 0;
        for (int k = 0; k < BIAS; k++) begin
            if (got_dn < dn) begin
                m[W * W * REP + c * BIAS + k] = 1'b1;
                got_dn++;
            end
        end
        for (int i = 0; i < W; i++) begin
            for (int r = 0; r < REP; r++) begin
                if (c - i >= 0 && c - i < W) begin
                    if (a[i] & b[c - i]) begin
                        if (got_dn < dn) begin
                            m[((i * W) + (c - i)) * REP + r] = 1'b1;
                            got_dn++;
                        end
                    end else if (got_up < up) begin
                        m[((i * W) + (c - i)) * REP + r] = 1'b1;
                        got_up++;
                    end
                end
            end
        end
    endtask

    initial begin
        int gu;
        int gd;
        int net;
        logic [15:0] exp;
        logic [15:0] first;
        logic [FW-1:0] m;

        // R2: reset state
        @(negedge clk);
        @(negedge clk);
        check("R2 reset state", product, 16'd0);
        rst = 1'b0;

        // table of single-column fault patterns (R1, R4, R5, R6, R7, R9)
        for (int t = 0; t < NROW; t++) begin
            m = '0;
            add_flips(T_A[t], T_B[t], T_C[t], T_UP[t], T_DN[t], m, gu, gd);
            net = gu - gd;
            exp = 16'(T_A[t]) * 16'(T_B[t]);
            if (net >= 4) exp = exp + (16'd1 << T_C[t]);
            if (net <= -5) exp = exp - (16'd1 << T_C[t]);
            @(negedge clk);
            op_a = T_A[t];
            op_b = T_B[t];
            flip_mask = m;
            @(negedge clk);
            check($sformatf("R1/R4/R5/R6/R7/R9 row %0d net %0d", t, net), product, exp);
        end

        // R8: every column faulted at once, each inside its window
        for (int n = 0; n < 20; n++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = 8'($urandom);
            b = 8'($urandom);
            m = '0;
            for (int c = 0; c < NCOL; c++) begin
                add_flips(a, b, c, int'($urandom % 4), int'($urandom % 5), m, gu, gd);
            end
            @(negedge clk);
            op_a = a;
            op_b = b;
            flip_mask = m;
            @(negedge clk);
            check("R8 all columns faulted", product, 16'(a) * 16'(b));
        end

        // R10: inputs held, output held
        @(negedge clk);
        op_a = 8'd99;
        op_b = 8'd123;
        flip_mask = '0;
        @(negedge clk);
        first = product;
        @(negedge clk);
        check("R10 hold cycle 1", first, 16'd12177);
        check("R10 hold cycle 2", product, first);

        // R2: reset mid-run with live operands
        rst = 1'b1;
        @(negedge clk);
        check("R2 mid-run reset", product, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset release", product, 16'd12177);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule